// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Registers

This block holds the host-visible control state of a two-channel bus-master DMA controller for a disk interface. A 16-byte I/O window is split into two 8-byte channel slices. Each slice carries a command byte, a status byte and a 32-bit pointer to a descriptor table. The host starts and stops transfers through the command byte and acknowledges events through the status byte. The pointer can be written a byte, a halfword or a word at a time.

The block drives one-cycle start and cancel pulses toward an external transfer engine. It also exports a current-pointer copy that the engine consumes. The engine reports interrupt and error events back through per-channel set inputs. Two vendor-defined byte slots per channel are not stored here: when the extension is enabled, they are forwarded to a side port; when it is disabled, they read as all ones.

Top module: `ide_bm_regs`

## Requirements
- R1: `addr[3]` selects the channel (0 or 1) and `addr[2:0]` selects the offset within it. Writes to one channel never change the registers, pulses or pointer of the other channel.
- R2: A write to offset 0 stores only bit 0 (run) and bit 3 (direction), so the stored value is the write data ANDed with 0x09. Reading offset 0 returns the stored byte.
- R3: A write to offset 0 with bit 0 clear raises that channel's `cancel` bit for exactly the cycle after the write and clears status bit 0 (active).
- R4: A write to offset 0 with bit 0 set, while status bit 0 is clear, sets status bit 0 and raises `start_pulse` for exactly the cycle after the write. If status bit 0 is already set, no start pulse is produced.
- R5: A write to offset 2 loads status bits 5 and 6 from the data and leaves bit 0 unchanged. Writing a 1 to bit 1 or bit 2 clears that bit; writing a 0 there leaves it as it was. Bits 3, 4 and 7 always read 0.
- R6: Offsets 4 to 7 hold the descriptor pointer. `wr_size` selects the access width: 0 is a byte, 1 is a halfword, 2 is a word. A byte or halfword write is placed at byte lane `addr[1:0]`; a word write replaces the whole pointer. Pointer bits 1:0 are always 0. Reading offset 4+k returns the pointer shifted right by 8*k bits.
- R7: Every pointer write also loads the same value into that channel's `cur_ptr` output.
- R8: `eng_set_irq` sets status bit 2 and `eng_set_err` sets status bit 1 on the next clock. A set wins over a host clear of the same bit in the same cycle.
- R9: Offsets 1 and 3 are vendor slots, numbered `vnd_wstrb` index = channel*2 + (offset==3). With `vendor_en` low, they read 0xFF and writes raise no strobe. With `vendor_en` high, a read returns byte index*8 of `vnd_rdata`, and a write raises the matching `vnd_wstrb` bit combinationally, with `vnd_wdata` = `wr_data[7:0]`.
- R10: Reset clears command, status, pointer and current-pointer state on both channels. `cancel` reads 2'b11 while reset is held and through the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Byte offset in the 16-byte window |
| wr_size | input | 2 | Write width: 0 byte, 1 halfword, 2 word |
| wr_data | input | 32 | Write data, lane 0 aligned |
| rd_data | output | 32 | Combinational read data for `addr` |
| vendor_en | input | 1 | Enables forwarding of the vendor slots |
| vnd_rdata | input | 32 | Vendor slot bytes, index = channel*2 + slot |
| vnd_wstrb | output | 4 | Vendor slot write strobes |
| vnd_wdata | output | 8 | Vendor slot write byte |
| eng_set_irq | input | 2 | Per-channel engine interrupt event |
| eng_set_err | input | 2 | Per-channel engine error event |
| start_pulse | output | 2 | Per-channel one-cycle start request |
| cancel | output | 2 | Per-channel one-cycle cancel request |
| cur_ptr | output | 64 | Current pointers, channel 1 in bits 63:32 |

## Verification
Two cases are hard to reach from the ports.

The first is a host clear of the interrupt bit landing in the same cycle as an engine set of that bit. The stimulus drives the status write and the set input on the same falling edge, so both are seen at one rising edge.

The second is a run write arriving while the channel is already active. It is reached by issuing two run writes back to back. The bench then checks for a missing start pulse while the stored direction bit still changes.

The pointer merge is walked through a table of mixed-width writes whose expected values accumulate from one entry to the next.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

    localparam int PTR_W  = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_VND0 = 3'd1;
    localparam logic [2:0] OFF_STAT = 3'd2;
    localparam logic [2:0] OFF_VND1 = 3'd3;

    localparam logic [7:0] CMD_KEEP   = 8'h09;
    localparam logic [7:0] STAT_PLAIN = 8'h60;
    localparam logic [7:0] STAT_W1C   = 8'h06;
    localparam logic [7:0] STAT_RO    = 8'h01;

    localparam int ST_ACTIVE = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_IRQ    = 2;

    typedef struct packed {
        logic [7:0]       cmd;
        logic [7:0]       stat;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] cur;
        logic             start;
        logic             cancel;
    } chan_regs_t;

endpackage

// File: rtl/ide_bm_ptr_merge.sv
module ide_bm_ptr_merge
    import ide_bm_pkg::*;
(
    input  logic [PTR_W-1:0] old_val,
    input  logic [PTR_W-1:0] wdata,
    input  logic [1:0]       lane,
    input  logic [1:0]       size,
    output logic [PTR_W-1:0] merged
);
    localparam int SHIFT_W = $clog2(PTR_W);

    logic [PTR_W-1:0]   mask_base;
    logic [PTR_W-1:0]   mask;
    logic [PTR_W-1:0]   data_sh;
    logic [SHIFT_W-1:0] shamt;

    always_comb begin
        case (size)
            SZ_BYTE: mask_base = {{(PTR_W-8){1'b0}}, 8'hFF};
            SZ_HALF: mask_base = {{(PTR_W-16){1'b0}}, 16'hFFFF};
            default: mask_base = '1;
        endcase
        if (size == SZ_BYTE || size == SZ_HALF) begin
            shamt = SHIFT_W'({lane, 3'b000});
        end else begin
            shamt = '0;
        end
        mask    = mask_base << shamt;
        data_sh = wdata << shamt;
        merged  = ((old_val & ~mask) | (data_sh & mask)) & ~PTR_W'(3);
    end

endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
    import ide_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       off,
    input  logic [1:0]       wr_size,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             set_irq,
    input  logic             set_err,
    output logic [7:0]       cmd_o,
    output logic [7:0]       stat_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] cur_o,
    output logic             start_o,
    output logic             cancel_o
);
    chan_regs_t       r_d, r_q;
    logic [PTR_W-1:0] ptr_merged;
    logic [7:0]       wbyte;

    assign wbyte = wr_data[7:0];

    ide_bm_ptr_merge u_merge (
        .old_val (r_q.ptr),
        .wdata   (wr_data),
        .lane    (off[1:0]),
        .size    (wr_size),
        .merged  (ptr_merged)
    );

    always_comb begin
        r_d        = r_q;
        r_d.start  = 1'b0;
        r_d.cancel = 1'b0;
        if (wr_en) begin
            if (off == OFF_CMD) begin
                r_d.cmd = wbyte & CMD_KEEP;
                if (!wbyte[0]) begin
                    r_d.cancel          = 1'b1;
                    r_d.stat[ST_ACTIVE] = 1'b0;
                end else if (!r_q.stat[ST_ACTIVE]) begin
                    r_d.stat[ST_ACTIVE] = 1'b1;
                    r_d.start           = 1'b1;
                end
            end else if (off == OFF_STAT) begin
                r_d.stat = (wbyte & STAT_PLAIN)
                         | (r_q.stat & STAT_RO)
                         | (r_q.stat & ~wbyte & STAT_W1C);
            end else if (off[2]) begin
                r_d.ptr = ptr_merged;
                r_d.cur = ptr_merged;
            end
        end
        if (set_irq) r_d.stat[ST_IRQ] = 1'b1;
        if (set_err) r_d.stat[ST_ERR] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.cancel <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o    = r_q.cmd;
    assign stat_o   = r_q.stat;
    assign ptr_o    = r_q.ptr;
    assign cur_o    = r_q.cur;
    assign start_o  = r_q.start;
    assign cancel_o = r_q.cancel;

    a_r3_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_CMD && !wbyte[0]) |=> (cancel_o && !stat_o[ST_ACTIVE]));

    a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_CMD && wbyte[0] && !stat_o[ST_ACTIVE]) |=> (start_o && stat_o[ST_ACTIVE]));

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_CMD && wbyte[0] && stat_o[ST_ACTIVE]) |=> !start_o);

    a_r5_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_STAT) |=> (stat_o[ST_ACTIVE] == $past(stat_o[ST_ACTIVE])));

    a_r7_cur_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off[2]) |=> (cur_o == ptr_o));

    a_r8_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_irq |=> stat_o[ST_IRQ]);

    a_r8_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> stat_o[ST_ERR]);

endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
    import ide_bm_pkg::*;
#(
    parameter int N_CHAN = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [3:0]                addr,
    input  logic [1:0]                wr_size,
    input  logic [31:0]               wr_data,
    output logic [31:0]               rd_data,
    input  logic                      vendor_en,
    input  logic [31:0]               vnd_rdata,
    output logic [3:0]                vnd_wstrb,
    output logic [7:0]                vnd_wdata,
    input  logic [1:0]                eng_set_irq,
    input  logic [1:0]                eng_set_err,
    output logic [1:0]                start_pulse,
    output logic [1:0]                cancel,
    output logic [63:0]               cur_ptr
);
    localparam int N_SLOT = 2 * N_CHAN;

    logic [2:0]       off;
    logic             ch_sel;
    logic [7:0]       cmd_v  [N_CHAN];
    logic [7:0]       stat_v [N_CHAN];
    logic [PTR_W-1:0] ptr_v  [N_CHAN];
    logic [PTR_W-1:0] cur_v  [N_CHAN];
    logic [1:0]       slot_idx;

    assign off      = addr[2:0];
    assign ch_sel   = addr[3];
    assign slot_idx = {ch_sel, off[1]};

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        ide_bm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (ch_sel == c[0])),
            .off      (off),
            .wr_size  (wr_size),
            .wr_data  (wr_data),
            .set_irq  (eng_set_irq[c]),
            .set_err  (eng_set_err[c]),
            .cmd_o    (cmd_v[c]),
            .stat_o   (stat_v[c]),
            .ptr_o    (ptr_v[c]),
            .cur_o    (cur_v[c]),
            .start_o  (start_pulse[c]),
            .cancel_o (cancel[c])
        );
        assign cur_ptr[c*PTR_W +: PTR_W] = cur_v[c];
    end

    always_comb begin
        vnd_wstrb = '0;
        vnd_wdata = wr_data[7:0];
        if (wr_en && vendor_en && (off == OFF_VND0 || off == OFF_VND1)) begin
            vnd_wstrb[slot_idx] = 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        case (off)
            OFF_CMD:  rd_data[7:0] = cmd_v[ch_sel];
            OFF_STAT: rd_data[7:0] = stat_v[ch_sel];
            OFF_VND0, OFF_VND1: begin
                if (vendor_en) rd_data[7:0] = vnd_rdata[slot_idx*8 +: 8];
                else           rd_data[7:0] = 8'hFF;
            end
            default:  rd_data = ptr_v[ch_sel] >> {off[1:0], 3'b000};
        endcase
    end

    a_r9_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !vendor_en |-> (vnd_wstrb == '0));

    a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vnd_wstrb));

    a_r1_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse));

    initial assert (N_SLOT == 4) else $error("vendor slot count must be 4");

endmodule

// File: tb/tb_ide_bm_regs.sv
module tb_ide_bm_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        vendor_en = 1'b0;
    logic [31:0] vnd_rdata = 32'hD4C3B2A1;
    logic [3:0]  vnd_wstrb;
    logic [7:0]  vnd_wdata;
    logic [1:0]  eng_set_irq = '0;
    logic [1:0]  eng_set_err = '0;
    logic [1:0]  start_pulse;
    logic [1:0]  cancel;
    logic [63:0] cur_ptr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ide_bm_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_size(wr_size),
        .wr_data(wr_data), .rd_data(rd_data), .vendor_en(vendor_en),
        .vnd_rdata(vnd_rdata), .vnd_wstrb(vnd_wstrb), .vnd_wdata(vnd_wdata),
        .eng_set_irq(eng_set_irq), .eng_set_err(eng_set_err),
        .start_pulse(start_pulse), .cancel(cancel), .cur_ptr(cur_ptr)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'd4,  2'd2, 32'h12345677, 32'h12345674},
        '{4'd5,  2'd0, 32'h000000AB, 32'h1234AB74},
        '{4'd6,  2'd1, 32'h0000BEEF, 32'hBEEFAB74},
        '{4'd4,  2'd0, 32'h000000FF, 32'hBEEFABFC},
        '{4'd4,  2'd1, 32'h00000003, 32'hBEEF0000},
        '{4'd7,  2'd0, 32'h00000001, 32'h01EF0000},
        '{4'd12, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFC}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_size = sz; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a; wr_en = 1'b0;
        #1 v = rd_data;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        // R10: cancel asserted on both channels while reset held
        #5;
        chk("R10 cancel in reset", 64'(cancel), 64'h3);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 cancel first edge", 64'(cancel), 64'h3);
        @(negedge clk);
        chk("R10 cancel released", 64'(cancel), 64'h0);
        rd(4'd0, v);  chk("R10 cmd0 reset", 64'(v), 64'h0);
        rd(4'd2, v);  chk("R10 stat0 reset", 64'(v), 64'h0);
        rd(4'd12, v); chk("R10 ptr1 reset", 64'(v), 64'h0);
        chk("R10 cur reset", cur_ptr, 64'h0);

        // R2 / R3: mask and stop
        wr(4'd0, 2'd0, 32'hFE);
        chk("R3 cancel pulse", 64'(cancel), 64'h1);
        chk("R4 no start on stop", 64'(start_pulse), 64'h0);
        rd(4'd0, v); chk("R2 cmd masked", 64'(v), 64'h08);

        // R4: start when idle
        wr(4'd0, 2'd0, 32'h01);
        chk("R4 start pulse", 64'(start_pulse), 64'h1);
        rd(4'd2, v); chk("R4 active set", 64'(v), 64'h01);
        @(negedge clk);
        chk("R4 start one cycle", 64'(start_pulse), 64'h0);
        wr(4'd0, 2'd0, 32'h09);
        chk("R4 no restart", 64'(start_pulse), 64'h0);
        rd(4'd0, v); chk("R2 cmd dir", 64'(v), 64'h09);
        rd(4'd8, v); chk("R1 ch1 cmd untouched", 64'(v), 64'h0);

        // R5: status plain bits, active kept
        wr(4'd2, 2'd0, 32'hFF);
        rd(4'd2, v); chk("R5 status load", 64'(v), 64'h61);

        // R8: engine sets
        @(negedge clk);
        eng_set_irq = 2'b01; eng_set_err = 2'b01;
        @(negedge clk);
        eng_set_irq = 2'b00; eng_set_err = 2'b00;
        rd(4'd2, v); chk("R8 engine set", 64'(v), 64'h67);
        rd(4'd10, v); chk("R1 ch1 status untouched", 64'(v), 64'h0);

        // R5: write-one-to-clear
        wr(4'd2, 2'd0, 32'h04);
        rd(4'd2, v); chk("R5 w1c irq", 64'(v), 64'h03);

        // R8: set wins over same-cycle clear
        @(negedge clk);
        addr = 4'd2; wr_size = 2'd0; wr_data = 32'h04; wr_en = 1'b1;
        eng_set_irq = 2'b01;
        @(negedge clk);
        wr_en = 1'b0; eng_set_irq = 2'b00;
        rd(4'd2, v); chk("R8 set wins", 64'(v), 64'h07);

        // R3: stop clears active
        wr(4'd0, 2'd0, 32'h00);
        chk("R3 cancel ch0 only", 64'(cancel), 64'h1);
        rd(4'd2, v); chk("R3 active cleared", 64'(v), 64'h06);

        // R6 / R7: pointer merge table
        for (int i = 0; i < 7; i++) begin
            wr(VECS[i].a, VECS[i].sz, VECS[i].d);
            rd({VECS[i].a[3], 3'd4}, v);
            chk("R6 ptr merge", 64'(v), 64'(VECS[i].exp));
            chk("R7 cur copy",
                VECS[i].a[3] ? 64'(cur_ptr[63:32]) : 64'(cur_ptr[31:0]),
                64'(VECS[i].exp));
        end
        rd(4'd4, v); chk("R1 ch0 ptr after ch1 write", 64'(v), 64'h01EF0000);
        rd(4'd6, v); chk("R6 lane read", 64'(v), 64'h000001EF);

        // R9: vendor slots
        rd(4'd1, v); chk("R9 disabled read", 64'(v), 64'hFF);
        @(negedge clk);
        addr = 4'd3; wr_data = 32'h5A; wr_en = 1'b1;
        #1 chk("R9 disabled no strobe", 64'(vnd_wstrb), 64'h0);
        vendor_en = 1'b1;
        #1 chk("R9 enabled strobe", 64'(vnd_wstrb), 64'h2);
        chk("R9 write byte", 64'(vnd_wdata), 64'h5A);
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'd1, v);  chk("R9 read slot0", 64'(v), 64'hA1);
        rd(4'd11, v); chk("R9 read ch1 slot1", 64'(v), 64'hD4);
        rd(4'd0, v);  chk("R9 cmd untouched by vendor", 64'(v), 64'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule